// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one DMA channel that copies a programmed number of bytes from a source address to a destination address. Software loads five configuration words through a small register port while the channel is idle, then pulses a start input. The channel alternates read and write requests on a word-wide memory port, moving one beat per read/write pair. After each completed write it steps both addresses and lowers the remaining byte count. When the count reaches zero it pulses a completion event.

Each side steps its address on its own: up, down or not at all. Memory-to-peripheral copies use a rising source and a fixed destination. Peripheral-to-memory copies use a fixed source and a rising destination. The beat width is 1 to 4 bytes. The size register counts down as the copy runs, so reading it returns the bytes not yet written. An abort pulse stops the channel at the next clock edge and raises both an abort event and a completion event.

Top module: `dma_channel`

## Requirements
- R1: After reset all five configuration registers read zero, `busy_o`, `mem_req_o`, `done_evt_o` and `abort_evt_o` are low.
- R2: The register map is: source address at offset 0x00, destination address at 0x04, byte count at 0x08, source mode at 0x0C, destination mode at 0x10. Each reads back the full written word, and any other offset reads zero. Writes are ignored while `busy_o` is high.
- R3: Bits [1:0] of each mode register select the address step: 0 steps the address up by the beat width after each beat, 1 steps it down by the beat width, and 2 or 3 holds it fixed.
- R4: Bits [9:8] of the source mode register hold the beat width minus one. Each beat is a read request (`mem_we_o`=0) at the source address, then a write request (`mem_we_o`=1) at the destination address carrying the read data. `mem_len_o` equals the beat width, and data bytes sit in ascending lanes starting at lane 0.
- R5: When the remaining count is smaller than the beat width, the final beat's `mem_len_o` equals the remaining count.
- R6: The byte-count register falls by `mem_len_o` on each accepted write and is otherwise unchanged while busy, so reading it mid-copy gives the bytes still to be written.
- R7: `done_evt_o` pulses for one cycle in the cycle after the last write is granted, and `busy_o` is low in that same cycle.
- R8: A start pulse while `busy_o` is high has no effect. The copy in flight ends with the expected beat count and exactly one completion pulse.
- R9: A start with a byte count of zero pulses `done_evt_o` in the next cycle without raising `busy_o` or `mem_req_o`.
- R10: An abort while busy drops `busy_o` and `mem_req_o` and pulses both `abort_evt_o` and `done_evt_o` in the next cycle. A grant taken in the same edge is discarded, and the count keeps the bytes not yet written. An abort while idle has no effect.
- R11: A request not yet granted keeps `mem_req_o` high and `mem_addr_o` unchanged in the next cycle unless aborted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Abort pulse |
| busy_o | output | 1 | Copy in progress |
| done_evt_o | output | 1 | Completion event pulse |
| abort_evt_o | output | 1 | Abort event pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Request byte address |
| mem_len_o | output | 3 | Bytes in this beat (1 to 4) |
| mem_wdata_o | output | 32 | Write data, low lanes valid |
| mem_gnt_i | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
The hardest states to reach from the ports are a start pulse or register write landing in the middle of a copy, and an abort landing after a known number of beats. The bench's memory model holds every grant back a programmable number of cycles, which stretches each beat. That leaves room to inject a second start and register writes while busy. For the abort case, the bench polls the live byte count and fires the abort the moment the count shows one finished beat. This fixes the residue it expects to find afterwards.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  localparam int CFG_AW = 8;

  localparam logic [CFG_AW-1:0] OFF_SRC_ADDR = 8'h00;
  localparam logic [CFG_AW-1:0] OFF_DST_ADDR = 8'h04;
  localparam logic [CFG_AW-1:0] OFF_SIZE     = 8'h08;
  localparam logic [CFG_AW-1:0] OFF_SRC_MODE = 8'h0C;
  localparam logic [CFG_AW-1:0] OFF_DST_MODE = 8'h10;

  localparam int STEP_LSB  = 0;
  localparam int WIDTH_LSB = 8;

  typedef enum logic [1:0] {
    STEP_INC = 2'd0,
    STEP_DEC = 2'd1,
    STEP_FIX = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } state_e;
endpackage

// File: rtl/dma_ch_addr_step.sv
module dma_ch_addr_step #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        step_i,
  input  logic [LEN_W-1:0]  width_i,
  output logic [ADDR_W-1:0] addr_o
);
  import dma_ch_pkg::*;

  logic [ADDR_W-1:0] delta;
  assign delta = ADDR_W'(width_i);

  always_comb begin
    unique case (step_i)
      STEP_INC: addr_o = addr_i + delta;
      STEP_DEC: addr_o = addr_i - delta;
      default:  addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int REG_W  = 32,
  parameter int LEN_W  = 3,
  parameter int BW_W   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_we_i,
  input  logic [dma_ch_pkg::CFG_AW-1:0]  cfg_addr_i,
  input  logic [REG_W-1:0]               cfg_wdata_i,
  output logic [REG_W-1:0]               cfg_rdata_o,
  input  logic                           busy_i,
  input  logic                           beat_done_i,
  input  logic [LEN_W-1:0]               beat_len_i,
  output logic [ADDR_W-1:0]              src_addr_o,
  output logic [ADDR_W-1:0]              dst_addr_o,
  output logic [SIZE_W-1:0]              size_o,
  output logic [LEN_W-1:0]               width_o
);
  import dma_ch_pkg::*;

  localparam int NSIDE = 2;

  logic [ADDR_W-1:0] addr_q [NSIDE];
  logic [REG_W-1:0]  mode_q [NSIDE];
  logic [ADDR_W-1:0] addr_nx[NSIDE];
  logic [SIZE_W-1:0] size_q;

  assign width_o = LEN_W'(mode_q[0][WIDTH_LSB +: BW_W]) + LEN_W'(1);

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_ch_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
      .addr_i (addr_q[g]),
      .step_i (mode_q[g][STEP_LSB +: 2]),
      .width_i(width_o),
      .addr_o (addr_nx[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q[0] <= '0;
      addr_q[1] <= '0;
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      size_q    <= '0;
    end else if (busy_i) begin
      if (beat_done_i) begin
        addr_q[0] <= addr_nx[0];
        addr_q[1] <= addr_nx[1];
        size_q    <= size_q - SIZE_W'(beat_len_i);
      end
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        OFF_SRC_ADDR: addr_q[0] <= ADDR_W'(cfg_wdata_i);
        OFF_DST_ADDR: addr_q[1] <= ADDR_W'(cfg_wdata_i);
        OFF_SIZE:     size_q    <= SIZE_W'(cfg_wdata_i);
        OFF_SRC_MODE: mode_q[0] <= cfg_wdata_i;
        OFF_DST_MODE: mode_q[1] <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (cfg_addr_i)
      OFF_SRC_ADDR: cfg_rdata_o = REG_W'(addr_q[0]);
      OFF_DST_ADDR: cfg_rdata_o = REG_W'(addr_q[1]);
      OFF_SIZE:     cfg_rdata_o = REG_W'(size_q);
      OFF_SRC_MODE: cfg_rdata_o = mode_q[0];
      OFF_DST_MODE: cfg_rdata_o = mode_q[1];
      default:      cfg_rdata_o = '0;
    endcase
  end

  assign src_addr_o = addr_q[0];
  assign dst_addr_o = addr_q[1];
  assign size_o     = size_q;

  // R6: count only moves on an accepted write
  p_size_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !beat_done_i |=> size_q == $past(size_q));
  p_size_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_done_i |=> size_q == $past(size_q) - SIZE_W'($past(beat_len_i)));
  // R3: fixed codes keep the source address
  p_src_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && mode_q[0][STEP_LSB+1] |=> addr_q[0] == $past(addr_q[0]));
  // R2: configuration locked while busy
  p_cfg_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !beat_done_i |=> addr_q[1] == $past(addr_q[1]) && mode_q[0] == $past(mode_q[0]));
endmodule

// File: rtl/dma_ch_fsm.sv
module dma_ch_fsm #(
  parameter int SIZE_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  width_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              beat_done_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_o
);
  import dma_ch_pkg::*;

  state_e state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic done_q, done_d, abt_q, abt_d;
  logic last_beat;

  assign len_o     = (size_i < SIZE_W'(width_i)) ? LEN_W'(size_i) : width_i;
  assign last_beat = (size_i == SIZE_W'(len_o));

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    abt_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (size_i == '0) done_d = 1'b1;
          else              state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (abort_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          abt_d   = 1'b1;
        end else if (gnt_i) begin
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (abort_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          abt_d   = 1'b1;
        end else if (gnt_i) begin
          state_d = last_beat ? ST_IDLE : ST_RD;
          done_d  = last_beat;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      done_q  <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      abt_q   <= abt_d;
      if (state_q == ST_RD && gnt_i && !abort_i) data_q <= rdata_i;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_o       = busy_o;
  assign we_o        = (state_q == ST_WR);
  assign wdata_o     = data_q;
  assign beat_done_o = we_o && gnt_i && !abort_i;
  assign done_o      = done_q;
  assign abort_o     = abt_q;

  // R10: abort event always paired with done, channel stops at once
  p_abort_pairs_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> done_o);
  p_abort_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && abort_i |=> !busy_o && abort_o);
  // R9: zero-length start completes without work
  p_zero_size_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && size_i == '0 |=> done_o && !busy_o);
  // R7: done never while busy
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              start_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              done_evt_o,
  output logic              abort_evt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [$clog2(DATA_W/8+1)-1:0] mem_len_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTES = DATA_W / 8;
  localparam int LEN_W = $clog2(BYTES + 1);
  localparam int BW_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [SIZE_W-1:0] size;
  logic [LEN_W-1:0]  width, beat_len;
  logic              beat_done;

  dma_ch_regs #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .REG_W(REG_W), .LEN_W(LEN_W), .BW_W(BW_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .busy_i     (busy_o),
    .beat_done_i(beat_done),
    .beat_len_i (beat_len),
    .src_addr_o (src_addr),
    .dst_addr_o (dst_addr),
    .size_o     (size),
    .width_o    (width)
  );

  dma_ch_fsm #(.SIZE_W(SIZE_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .size_i     (size),
    .width_i    (width),
    .gnt_i      (mem_gnt_i),
    .rdata_i    (mem_rdata_i),
    .req_o      (mem_req_o),
    .we_o       (mem_we_o),
    .len_o      (beat_len),
    .wdata_o    (mem_wdata_o),
    .beat_done_o(beat_done),
    .busy_o     (busy_o),
    .done_o     (done_evt_o),
    .abort_o    (abort_evt_o)
  );

  assign mem_addr_o = mem_we_o ? dst_addr : src_addr;
  assign mem_len_o  = beat_len;

  // R11: pending request holds
  p_req_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i && !abort_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R4/R5: beat length within 1..width
  p_len_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_len_o != '0 && mem_len_o <= width);
endmodule

// File: tb/dma_channel_bench.sv
module dma_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        start = 1'b0, abort = 1'b0;
  logic        busy, done_evt, abort_evt;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [2:0]  mem_len;

  int n_chk = 0, n_fail = 0;
  int lat = 0, cnt = 0, wtaken = 0, done_cnt = 0;
  logic pend_w = 1'b0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_channel u_dma_channel (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .start_i(start), .abort_i(abort),
    .busy_o(busy), .done_evt_o(done_evt), .abort_evt_o(abort_evt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  // memory model: grants after lat waiting cycles, decided at negedge
  always @(negedge clk) begin
    if (mem_gnt && pend_w) wtaken++;
    if (done_evt) done_cnt++;
    if (mem_req && cnt >= lat) begin
      mem_gnt = 1'b1;
      pend_w  = mem_we;
      cnt     = 0;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (k < int'(mem_len)) mem[8'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
      end else begin
        for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = mem[8'(mem_addr + 32'(k))];
      end
    end else begin
      mem_gnt = 1'b0;
      pend_w  = 1'b0;
      cnt     = mem_req ? cnt + 1 : 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic setup(input logic [31:0] s, d, n, sm, dm);
    cfg_wr(8'h00, s); cfg_wr(8'h04, d); cfg_wr(8'h08, n);
    cfg_wr(8'h0C, sm); cfg_wr(8'h10, dm);
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 wtaken = 0; start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
  endtask

  task automatic wait_done(input int beats, input string tag);
    int prev = wtaken;
    bit seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      prev = wtaken;
      @(negedge clk); #1;
      if (done_evt) seen = 1'b1;
    end
    check({tag, " done seen"}, 32'(seen), 1);
    check({tag, " busy low at done"}, 32'(busy), 0);
    check({tag, " no abort evt"}, 32'(abort_evt), 0);
    check({tag, " beat count"}, 32'(wtaken), 32'(beats));
    check({tag, " R7 done right after last write"}, 32'(prev), 32'(beats - 1));
    @(negedge clk); #1;
    check({tag, " R7 done one cycle"}, 32'(done_evt), 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 busy", 32'(busy), 0);
    check("R1 req", 32'(mem_req), 0);
    check("R1 done/abort", {30'd0, done_evt, abort_evt}, 0);
    for (int a = 0; a <= 16; a += 4) begin
      cfg_rd(8'(a), v);
      check("R1 reg zero", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] v;
    setup(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0123, 32'hFFFF_0302, 32'h8000_0001);
    cfg_rd(8'h00, v); check("R2 src addr", v, 32'h1234_5678);
    cfg_rd(8'h04, v); check("R2 dst addr", v, 32'h9ABC_DEF0);
    cfg_rd(8'h08, v); check("R2 size", v, 32'h0000_0123);
    cfg_rd(8'h0C, v); check("R2 src mode", v, 32'hFFFF_0302);
    cfg_rd(8'h10, v); check("R2 dst mode", v, 32'h8000_0001);
    cfg_rd(8'h3C, v); check("R2 unmapped", v, 0);
  endtask

  task automatic t_mem_to_periph();
    logic [31:0] v;
    lat = 1;
    setup(32'h10, 32'hF0, 32'd10, 32'h0300, 32'h0002);
    pulse_start();
    wait_done(3, "R4 m2p");
    check("R5 m2p last short beat F0", 32'(mem[8'hF0]), 32'(init_val(8'h18)));
    check("R5 m2p last short beat F1", 32'(mem[8'hF1]), 32'(init_val(8'h19)));
    check("R4 m2p full beat F3", 32'(mem[8'hF3]), 32'(init_val(8'h17)));
    cfg_rd(8'h00, v); check("R3 inc src by width", v, 32'h1C);
    cfg_rd(8'h04, v); check("R3 fixed dst", v, 32'hF0);
    cfg_rd(8'h08, v); check("R6 size zero at end", v, 0);
  endtask

  task automatic t_periph_to_mem();
    logic [31:0] v;
    lat = 0;
    setup(32'h30, 32'hA0, 32'd5, 32'h0102, 32'h0000);
    pulse_start();
    wait_done(3, "R4 p2m");
    check("R3 p2m A0", 32'(mem[8'hA0]), 32'(init_val(8'h30)));
    check("R3 p2m A3", 32'(mem[8'hA3]), 32'(init_val(8'h31)));
    check("R5 p2m A4", 32'(mem[8'hA4]), 32'(init_val(8'h30)));
    check("R5 p2m A5 untouched", 32'(mem[8'hA5]), 32'(init_val(8'hA5)));
    cfg_rd(8'h00, v); check("R3 p2m fixed src", v, 32'h30);
    cfg_rd(8'h04, v); check("R3 p2m dst", v, 32'hA6);
  endtask

  task automatic t_decrement();
    logic [31:0] v;
    lat = 2;
    setup(32'h43, 32'h80, 32'd4, 32'h0001, 32'h0000);
    pulse_start();
    wait_done(4, "R3 dec");
    for (int k = 0; k < 4; k++)
      check("R3 dec reversed byte", 32'(mem[8'(8'h80 + k)]), 32'(init_val(8'h43 - k)));
    cfg_rd(8'h00, v); check("R3 dec src end", v, 32'h3F);
    cfg_rd(8'h04, v); check("R3 dec dst end", v, 32'h84);
  endtask

  task automatic t_width3();
    logic [31:0] v;
    lat = 0;
    setup(32'h50, 32'hC0, 32'd7, 32'h0200, 32'h0000);
    pulse_start();
    wait_done(3, "R4 w3");
    check("R4 w3 C2", 32'(mem[8'hC2]), 32'(init_val(8'h52)));
    check("R5 w3 C6", 32'(mem[8'hC6]), 32'(init_val(8'h56)));
    check("R5 w3 C7 untouched", 32'(mem[8'hC7]), 32'(init_val(8'hC7)));
    cfg_rd(8'h00, v); check("R4 w3 src", v, 32'h59);
  endtask

  task automatic t_zero();
    int d0 = done_cnt;
    setup(32'h0, 32'h0, 32'd0, 32'h0, 32'h0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    check("R9 done next cycle", 32'(done_evt), 1);
    check("R9 busy stays low", 32'(busy), 0);
    check("R9 no request", 32'(mem_req), 0);
    @(negedge clk); #1;
    check("R9 single done", 32'(done_cnt - d0), 1);
  endtask

  task automatic t_busy_start();
    logic [31:0] v;
    int d0;
    lat = 3;
    setup(32'h00, 32'hE0, 32'd8, 32'h0000, 32'h0000);
    d0 = done_cnt;
    pulse_start();
    repeat (6) @(negedge clk);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cfg_wr(8'h08, 32'h100);
    cfg_wr(8'h00, 32'h77);
    cfg_rd(8'h08, v);
    check("R6 live residue", v, 32'(8 - wtaken));
    check("R8 still busy", 32'(busy), 1);
    wait_done(8, "R8 busy start");
    cfg_rd(8'h00, v); check("R2 write ignored while busy", v, 32'h08);
    repeat (5) @(negedge clk); #1;
    check("R8 one done only", 32'(done_cnt - d0), 1);
    check("R8 no restart", 32'(busy), 0);
  endtask

  task automatic t_abort();
    logic [31:0] v = '0;
    lat = 2;
    setup(32'h00, 32'hD0, 32'd16, 32'h0300, 32'h0000);
    pulse_start();
    for (int i = 0; i < 200 && v != 32'd12; i++) cfg_rd(8'h08, v);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0; #1;
    check("R10 abort evt", 32'(abort_evt), 1);
    check("R10 done with abort", 32'(done_evt), 1);
    check("R10 busy drops", 32'(busy), 0);
    check("R10 req drops", 32'(mem_req), 0);
    @(negedge clk); #1;
    check("R10 pulse ends", {30'd0, done_evt, abort_evt}, 0);
    cfg_rd(8'h08, v); check("R10 residue kept", v, 32'd12);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0; #1;
    check("R10 idle abort no evt", {30'd0, done_evt, abort_evt}, 0);
    cfg_rd(8'h08, v); check("R10 idle abort no change", v, 32'd12);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_mem_to_periph();
    t_periph_to_mem();
    t_decrement();
    t_width3();
    t_zero();
    t_busy_start();
    t_abort();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule